// File: doc/BRIEF.md
# DDR2 Power-Up Initialisation Sequencer

This block walks a DDR2 memory through its power-up mode-register sequence before any normal traffic is allowed. It hands each command to the memory controller's direct-command path as a 32-bit word with a valid/ready handshake. Between commands it waits for a programmable number of cycles, and the wait it chooses depends on the command that was just accepted. The same twelve-command sequence runs once per chip select. A parameter sets whether there are one or two chip selects.

Periodic refresh stays off while the sequence runs. When the last command of the last rank has had its wait, the block raises `init_done` and `auto_ref_en`. From then on a free-running interval counter emits a one-cycle `ref_req` pulse every `ref_interval` cycles. For a 7.8 µs period the interval is the clock frequency times 7.8 µs, for example 0x30C cycles at 100 MHz.

Top module: `ddr2_init_seq`

## Requirements
- R1: After a synchronous active-low reset, `cmd_valid`, `init_done`, `auto_ref_en` and `ref_req` are all low, and they stay low until `start` is seen high on a clock edge.
- R2: The command word is laid out as follows. Bits [27:24] hold the operation: 0 = mode register write, 1 = precharge-all, 5 = refresh, 7 = deselect. Bit 20 holds the chip select. Bits [17:16] hold the mode-register bank. Bits [15:0] hold the register value. All other bits are zero.
- R3: For each rank the words appear in this order: deselect; precharge-all; bank 2 with value 0; bank 3 with value 0; bank 1 with value 0x400; bank 0 with value 0x542 (DLL reset, bit 8 set); precharge-all; refresh; refresh; bank 0 with value 0x442; bank 1 with value 0x780; bank 1 with value 0x400.
- R4: Once `cmd_valid` is high it stays high, with `cmd_word` unchanged, until a clock edge where `cmd_ready` is also high. That edge accepts the command.
- R5: After a command is accepted, `cmd_valid` stays low for exactly W+1 cycles. W depends on the accepted command:
  - 0 after a deselect;
  - `t_rp` after a precharge-all;
  - `t_rfc` after a refresh;
  - `t_dll` after the bank 0 write with value 0x542;
  - `t_mrd` after every other mode-register write.
- R6: When NUM_RANKS is 2, the full R3 sequence runs with chip select 0 and then again with chip select 1. When NUM_RANKS is 1, only the chip select 0 pass is issued, which makes twelve commands.
- R7: `init_done` and `auto_ref_en` rise together in the cycle after the final command's W+1 quiet cycles. Before that point, `ref_req` never pulses.
- R8: Once `init_done` is high, `ref_req` pulses for one cycle. The first pulse comes in cycle index `ref_interval`-1, counting the first `init_done` cycle as index 0, and the pulses repeat every `ref_interval` cycles. The value of `ref_interval` must be at least 2.
- R9: A `start` pulse while the sequence is running has no effect: the command stream continues unchanged.
- R10: Once `init_done` is high it stays high, and `cmd_valid` never rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the sequence (honoured only when idle) |
| t_rp | input | CNT_W | Wait after precharge-all |
| t_rfc | input | CNT_W | Wait after refresh |
| t_mrd | input | CNT_W | Wait after a mode-register write |
| t_dll | input | CNT_W | Wait after the DLL-reset write |
| ref_interval | input | REF_W | Refresh period in cycles |
| cmd_word | output | 32 | Direct command word |
| cmd_valid | output | 1 | Command word is valid |
| cmd_ready | input | 1 | Controller accepts the command |
| auto_ref_en | output | 1 | Periodic refresh enabled |
| ref_req | output | 1 | One-cycle refresh request |
| init_done | output | 1 | Sequence complete |

## Verification
A step counter or rank register that is off by one shows up at the ports on the very next accepted command. The word arrives with the wrong operation, bank, value or chip select, and the scoreboard flags it at that handshake. A wrong wait selection does not change any word, so it shows only as a quiet gap of the wrong length, and that error appears before the following command is presented. Faults in the refresh counter stay hidden until `init_done` is high. They then show as a first pulse or a period that misses its expected cycle, within one refresh interval.

// File: rtl/ddr2_init_pkg.sv
// Shared types for the DDR2 init sequencer: operation codes, wait classes,
// the per-step descriptor and the command word packer.
// Assumes a 16-bit register value field in the low bits of the word.
package ddr2_init_pkg;

    typedef enum logic [3:0] {
        OP_MRW   = 4'd0,
        OP_PALL  = 4'd1,
        OP_REF   = 4'd5,
        OP_DESEL = 4'd7
    } op_t;

    typedef enum logic [2:0] {
        WC_NONE,
        WC_RP,
        WC_RFC,
        WC_MRD,
        WC_DLL
    } wcls_t;

    typedef struct packed {
        op_t         op;
        logic [1:0]  bank;
        logic [15:0] value;
        wcls_t       wcls;
    } step_t;

    localparam int unsigned NUM_STEPS = 12;

    // Pack operation, chip select, bank and value into the 32-bit word.
    function automatic logic [31:0] pack_word(op_t op, logic cs,
                                              logic [1:0] bank,
                                              logic [15:0] value);
        return {4'h0, op, 3'b000, cs, 2'b00, bank, value};
    endfunction

endpackage

// File: rtl/ddr2_step_rom.sv
// Step table: maps a step index (0..11) to the command that step issues
// and the class of wait that follows it. Purely combinational.
// Assumes indices beyond the last step are never presented; they decode
// to a deselect with no wait.
module ddr2_step_rom
    import ddr2_init_pkg::*;
(
    input  logic [3:0] step_idx,
    output step_t      step
);

    // Decode one step of the per-rank ritual.
    always_comb begin
        step = '{op: OP_DESEL, bank: 2'd0, value: 16'h0000, wcls: WC_NONE};
        case (step_idx)
            4'd0:  step = '{op: OP_DESEL, bank: 2'd0, value: 16'h0000, wcls: WC_NONE};
            4'd1:  step = '{op: OP_PALL,  bank: 2'd0, value: 16'h0000, wcls: WC_RP};
            4'd2:  step = '{op: OP_MRW,   bank: 2'd2, value: 16'h0000, wcls: WC_MRD};
            4'd3:  step = '{op: OP_MRW,   bank: 2'd3, value: 16'h0000, wcls: WC_MRD};
            4'd4:  step = '{op: OP_MRW,   bank: 2'd1, value: 16'h0400, wcls: WC_MRD};
            4'd5:  step = '{op: OP_MRW,   bank: 2'd0, value: 16'h0542, wcls: WC_DLL};
            4'd6:  step = '{op: OP_PALL,  bank: 2'd0, value: 16'h0000, wcls: WC_RP};
            4'd7:  step = '{op: OP_REF,   bank: 2'd0, value: 16'h0000, wcls: WC_RFC};
            4'd8:  step = '{op: OP_REF,   bank: 2'd0, value: 16'h0000, wcls: WC_RFC};
            4'd9:  step = '{op: OP_MRW,   bank: 2'd0, value: 16'h0442, wcls: WC_MRD};
            4'd10: step = '{op: OP_MRW,   bank: 2'd1, value: 16'h0780, wcls: WC_MRD};
            4'd11: step = '{op: OP_MRW,   bank: 2'd1, value: 16'h0400, wcls: WC_MRD};
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr2_wait_timer.sv
// Down-counter for inter-command gaps. A load sets the count; it then
// decrements once per cycle and rests at zero. The caller leaves its wait
// state on the cycle the count reads zero, giving load_val+1 wait cycles.
module ddr2_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             cnt_zero
);

    logic [CNT_W-1:0] cnt;

    // Load on request, otherwise count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign cnt_zero = (cnt == '0);

    // R5: an unloaded nonzero count falls by exactly one per cycle.
    p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/ddr2_ref_timer.sv
// Periodic refresh pacer. While enabled, counts cycles and emits a
// one-cycle tick every `interval` cycles, the first in cycle interval-1.
// Assumes interval >= 2; held at zero while disabled.
module ddr2_ref_timer #(
    parameter int REF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [REF_W-1:0] interval,
    output logic             tick
);

    logic [REF_W-1:0] cnt;
    logic [REF_W-1:0] last;

    assign last = interval - 1'b1;
    assign tick = en && (cnt == last);

    // Advance the interval counter and wrap on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt <= '0;
        else if (cnt >= last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R8: a tick never lasts two cycles when the interval is legal.
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && interval > 1) |=> !tick);

endmodule

// File: rtl/ddr2_init_seq.sv
// DDR2 power-up sequencer top. Walks the step table once per rank through
// a valid/ready direct-command port, inserting a class-dependent wait after
// each accepted command, then enables periodic refresh.
// Assumes: start is honoured only from idle; ref_interval >= 2.
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int NUM_RANKS = 2,
    parameter int CNT_W     = 16,
    parameter int REF_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] t_rp,
    input  logic [CNT_W-1:0] t_rfc,
    input  logic [CNT_W-1:0] t_mrd,
    input  logic [CNT_W-1:0] t_dll,
    input  logic [REF_W-1:0] ref_interval,
    output logic [31:0]      cmd_word,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic             auto_ref_en,
    output logic             ref_req,
    output logic             init_done
);

    localparam logic [3:0] LAST_STEP = 4'(NUM_STEPS - 1);

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_t;

    state_t           state;
    logic [3:0]       step_idx;
    logic             rank;
    logic             last_rank;
    step_t            cur;
    logic [CNT_W-1:0] wait_val;
    logic             accept;
    logic             gap_over;
    logic             finished;

    ddr2_step_rom u_rom (
        .step_idx (step_idx),
        .step     (cur)
    );

    // Choose the wait that follows the current command.
    always_comb begin
        case (cur.wcls)
            WC_RP:   wait_val = t_rp;
            WC_RFC:  wait_val = t_rfc;
            WC_MRD:  wait_val = t_mrd;
            WC_DLL:  wait_val = t_dll;
            default: wait_val = '0;
        endcase
    end

    assign accept = (state == S_ISSUE) && cmd_ready;

    ddr2_wait_timer #(.CNT_W(CNT_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (wait_val),
        .cnt_zero (gap_over)
    );

    generate
        if (NUM_RANKS > 1) begin : g_two_rank
            assign last_rank = rank;
        end else begin : g_one_rank
            assign last_rank = 1'b1;
        end
    endgenerate

    // Sequence control: step through the table, then ranks, then done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            step_idx <= '0;
            rank     <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    state    <= S_ISSUE;
                    step_idx <= '0;
                    rank     <= 1'b0;
                end
                S_ISSUE: if (cmd_ready) state <= S_WAIT;
                S_WAIT: if (gap_over) begin
                    if (step_idx != LAST_STEP) begin
                        step_idx <= step_idx + 1'b1;
                        state    <= S_ISSUE;
                    end else if (!last_rank) begin
                        step_idx <= '0;
                        rank     <= 1'b1;
                        state    <= S_ISSUE;
                    end else begin
                        state    <= S_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign finished    = (state == S_DONE);
    assign init_done   = finished;
    assign auto_ref_en = finished;
    assign cmd_valid   = (state == S_ISSUE);
    assign cmd_word    = pack_word(cur.op, rank, cur.bank, cur.value);

    ddr2_ref_timer #(.REF_W(REF_W)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (finished),
        .interval (ref_interval),
        .tick     (ref_req)
    );

    // R4: a pending command holds its word until accepted.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_word)));

    // R2: reserved bits of a presented word are zero.
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_word[31:28] == 4'h0 && cmd_word[23:21] == 3'b000
                       && cmd_word[19:18] == 2'b00));

    // R7: no refresh request before the sequence completes.
    p_no_early_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !ref_req);

    // R10: completion is sticky and silences the command port.
    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> (init_done && !cmd_valid));

endmodule

// File: tb/sim_ddr2_init_seq.sv
`timescale 1ns/1ps
module sim_ddr2_init_seq;

    localparam int CNT_W = 16;
    localparam int REF_W = 16;
    localparam int TRP = 3, TRFC = 5, TMRD = 2, TDLL = 20, RINT = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic rdy0 = 1'b0;
    logic [7:0] lfsr = 8'h5A;

    logic [31:0] w0, w1;
    logic v0, v1, are0, are1, rr0, rr1, dn0, dn1;

    always #2.5 clk = ~clk;

    ddr2_init_seq #(.NUM_RANKS(2), .CNT_W(CNT_W), .REF_W(REF_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .t_rp(16'(TRP)), .t_rfc(16'(TRFC)), .t_mrd(16'(TMRD)), .t_dll(16'(TDLL)),
        .ref_interval(16'(RINT)),
        .cmd_word(w0), .cmd_valid(v0), .cmd_ready(rdy0),
        .auto_ref_en(are0), .ref_req(rr0), .init_done(dn0));

    ddr2_init_seq #(.NUM_RANKS(1), .CNT_W(CNT_W), .REF_W(REF_W)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .t_rp(16'(TRP)), .t_rfc(16'(TRFC)), .t_mrd(16'(TMRD)), .t_dll(16'(TDLL)),
        .ref_interval(16'(RINT)),
        .cmd_word(w1), .cmd_valid(v1), .cmd_ready(1'b1),
        .auto_ref_en(are1), .ref_req(rr1), .init_done(dn1));

    typedef struct { logic [31:0] w; int wt; } exp_t;
    exp_t q[$];

    int checks = 0, fails = 0, cyc = 0;
    bit wd = 0, finished = 0, started = 0;
    int accepted = 0;

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Driver side: push the expected words and the wait that follows each.
    task automatic push(logic [31:0] w, int wt);
        exp_t e;
        e.w = w; e.wt = wt;
        q.push_back(e);
    endtask

    task automatic push_rank(logic cs);
        logic [31:0] c;
        c = {11'd0, cs, 20'd0};
        push(32'h0700_0000 | c, 0);     // deselect
        push(32'h0100_0000 | c, TRP);   // precharge-all
        push(32'h0002_0000 | c, TMRD);  // bank 2
        push(32'h0003_0000 | c, TMRD);  // bank 3
        push(32'h0001_0400 | c, TMRD);  // bank 1 DLL on
        push(32'h0000_0542 | c, TDLL);  // DLL reset
        push(32'h0100_0000 | c, TRP);
        push(32'h0500_0000 | c, TRFC);
        push(32'h0500_0000 | c, TRFC);
        push(32'h0000_0442 | c, TMRD);
        push(32'h0001_0780 | c, TMRD);
        push(32'h0001_0400 | c, TMRD);
    endtask

    // Ready pattern with stalls, changed just after each rising edge.
    initial forever begin
        @(posedge clk); #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rdy0 = lfsr[0] | lfsr[2];
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) wd = 1;
    end

    // Monitor: compare the design's stream against the scoreboard.
    bit pending = 0, have_prev = 0, done_seen = 0, done1_seen = 0;
    logic [31:0] prev_w = '0;
    int low_cnt = 0, last_wt = 0, done_idx = 0, next_exp = RINT - 1, pulses = 0;
    int cnt1 = 0;
    always @(negedge clk) begin
        if (rst_n && started && !finished) begin
            if (!dn0) begin
                chk(!are0 && !rr0, "R7 quiet before done", {30'd0, are0, rr0}, 32'd0);
                if (v0) begin
                    if (pending) chk(w0 == prev_w, "R4 hold", w0, prev_w);
                    if (rdy0) begin
                        if (q.size() == 0) begin
                            chk(0, "R6 extra command", w0, 32'd0);
                        end else begin
                            exp_t e;
                            e = q.pop_front();
                            chk(w0 == e.w, "R3/R2 word", w0, e.w);
                            if (have_prev)
                                chk(low_cnt == last_wt + 1, "R5 gap", low_cnt, last_wt + 1);
                            last_wt = e.wt;
                        end
                        accepted++;
                        have_prev = 1; low_cnt = 0; pending = 0;
                    end else begin
                        pending = 1; prev_w = w0;
                    end
                end else begin
                    low_cnt++;
                end
            end else begin
                if (!done_seen) begin
                    done_seen = 1;
                    chk(low_cnt == last_wt + 1, "R7 done timing", low_cnt, last_wt + 1);
                    chk(q.size() == 0, "R6 all commands", q.size(), 0);
                    chk(are0, "R7 auto_ref_en", {31'd0, are0}, 32'd1);
                end
                chk(!v0, "R10 no command after done", {31'd0, v0}, 32'd0);
                if (rr0) begin
                    chk(done_idx == next_exp, "R8 pulse cycle", done_idx, next_exp);
                    next_exp = done_idx + RINT; pulses++;
                end else if (done_idx == next_exp) begin
                    chk(0, "R8 missing pulse", done_idx, next_exp);
                    next_exp = done_idx + RINT;
                end
                done_idx++;
                if (pulses == 3) finished = 1;
            end
            // Single-rank instance.
            if (!dn1) begin
                if (v1) begin
                    cnt1++;
                    chk(w1[20] == 1'b0, "R6 single rank cs", w1, w1 & ~32'h0010_0000);
                end
            end else if (!done1_seen) begin
                done1_seen = 1;
                chk(cnt1 == 12, "R6 single rank count", cnt1, 12);
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        push_rank(1'b0);
        push_rank(1'b1);
        // R1: idle and silent after reset until start.
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!v0 && !dn0 && !are0 && !rr0, "R1 reset state",
                {28'd0, v0, dn0, are0, rr0}, 32'd0);
        end
        @(posedge clk); #1 start = 1'b1; started = 1;
        @(posedge clk); #1 start = 1'b0;
        // R9: a second start during the sequence must not restart it.
        wait (accepted >= 5 || wd);
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        wait (finished || wd);
        if (wd) chk(0, "watchdog", cyc, 0);
        chk(done1_seen, "R6 single rank done", {31'd0, done1_seen}, 32'd1);
        repeat (2) @(negedge clk);
        chk(dn0 && dn1, "R10 sticky done", {30'd0, dn0, dn1}, 32'd3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule